// File: doc/BRIEF.md
# LCD Controller Register Bank and Interrupt Combiner

This block is the software-visible register bank of a simple LCD controller. A 32-bit write port and a combinational read port, both addressed by byte address, reach six word registers: a control word, two geometry words that pack a ten-bit panel dimension with timing fields, a raw timing word, a read-only status word and a sub-panel word. The stored control, geometry and sub-panel values are driven out continuously to the frame sequencer, which fetches pixels and generates panel timing outside this block.

The frame sequencer reports three events back as level flags: frame complete, palette loaded and sync error. The block exposes them in the status word and folds them into one registered level interrupt. The two completion flags each pass through their own mask bit held in the control word. The sync error always interrupts. Each write that flips the enable bit also produces a one-cycle pulse, so the sequencer can start or stop a frame without polling.

Read-back is not a plain echo of the written data. Some words carry bits that always read as one. The control word reports the panel-type bit in two places. The geometry words store the dimension as the written count plus one and return it minus one.

Top module: `lcdc_csr`

## Requirements
- R1: After reset, all outputs are zero. Reads return 0xfe000c34 at 0x00, 0x000003ff at 0x04 and 0x08, 0xfc000000 at 0x0c, and zero at 0x10 and 0x14.
- R2: A write to 0x00 updates the control outputs from the written data. Enable comes from bit 0, mono from bit 1, the interrupt mask from bits 4:3, the panel-type bit from bit 7 and the palette-load mode from bits 21:20. The bits under 0x01cff300 are also retained.
- R3: A read of 0x00 returns the retained bits, the enable, mono, mask, panel-type and palette-mode fields in their written positions, and the panel-type bit again in bit 23, all ORed with 0xfe000c34.
- R4: A write to 0x04 sets width_o to data[9:0]+1 and keeps data[31:10]. A read returns those kept bits in 31:10 and (width_o-1) modulo 1024 in 9:0, ORed with 0x0000000f.
- R5: A write to 0x08 sets height_o to data[9:0]+1 and keeps data[31:10]. A read returns the same packing with nothing ORed in.
- R6: A write to 0x0c stores all 32 bits. A read returns them ORed with 0xfc000000.
- R7: A read of 0x10 returns the palette-loaded input in bit 6, sync error in bit 2 and frame complete in bit 0, with the other bits zero. A write to 0x10 changes no register and no output.
- R8: A write to 0x14 stores data ANDed with 0xa1ffffff. The stored value is driven on subpanel_o and returned by reads.
- R9: One clock after the inputs are applied, irq_o equals (frame complete AND mask bit 0) OR (palette loaded AND mask bit 1) OR sync error. Here mask bit 0 is control bit 3 and mask bit 1 is control bit 4.
- R10: enable_chg_o is high for exactly the one cycle after a write to 0x00 whose bit 0 differs from the stored enable. A write that leaves enable unchanged gives no pulse.
- R11: Reads of any other address, including misaligned ones, return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| frame_done_i | input | 1 | Frame complete flag from the sequencer |
| palette_done_i | input | 1 | Palette loaded flag from the sequencer |
| sync_err_i | input | 1 | Sync error flag from the sequencer |
| irq_o | output | 1 | Registered level interrupt |
| enable_o | output | 1 | Controller enable |
| enable_chg_o | output | 1 | One-cycle pulse after enable flips |
| plm_o | output | 2 | Palette-load mode |
| tft_o | output | 1 | Panel-type select |
| mono_o | output | 1 | Monochrome select |
| width_o | output | 11 | Panel width in pixels (1 to 1024) |
| height_o | output | 11 | Panel height in lines (1 to 1024) |
| subpanel_o | output | 32 | Sub-panel configuration |

## Verification
The properties assume the event flags and the write strobe are free of X and change only between clock edges. The interrupt and pulse checks hold only while the cycle before them is itself out of reset. The stimulus keeps to this: every input moves one time unit after a rising edge, and all inputs are held at zero through reset. The bench exercises each flag and mask combination with stable inputs held across a full cycle, so that every registered interrupt value can be traced to one set of inputs.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int DATA_W = 32;
    localparam int GEOM_W = 10;
    localparam int TIMF_W = DATA_W - GEOM_W;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_GEOM_X = 8'h04;
    localparam logic [7:0] OFS_GEOM_Y = 8'h08;
    localparam logic [7:0] OFS_TIMRAW = 8'h0c;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_SUBP   = 8'h14;

    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01cf_f300;
    localparam logic [DATA_W-1:0] CTRL_RD_ONES   = 32'hfe00_0c34;
    localparam logic [DATA_W-1:0] GEOMX_RD_ONES  = 32'h0000_000f;
    localparam logic [DATA_W-1:0] TIMRAW_RD_ONES = 32'hfc00_0000;
    localparam logic [DATA_W-1:0] SUBP_KEEP_MASK = 32'ha1ff_ffff;

    localparam int EN_BIT      = 0;
    localparam int MONO_BIT    = 1;
    localparam int MASK_LSB    = 3;
    localparam int TFT_BIT     = 7;
    localparam int PLM_LSB     = 20;
    localparam int TFT_DUP_BIT = 23;

    localparam int ST_FRAME_BIT = 0;
    localparam int ST_SYNC_BIT  = 2;
    localparam int ST_PAL_BIT   = 6;

    localparam int NUM_MASKED = 2;

    typedef struct packed {
        logic                  enable;
        logic                  en_chg;
        logic [1:0]            plm;
        logic                  tft;
        logic                  mono;
        logic [NUM_MASKED-1:0] irq_mask;
        logic [DATA_W-1:0]     ctrl_keep;
        logic [GEOM_W:0]       width;
        logic [TIMF_W-1:0]     timf0;
        logic [GEOM_W:0]       height;
        logic [TIMF_W-1:0]     timf1;
        logic [DATA_W-1:0]     timraw;
        logic [DATA_W-1:0]     subpanel;
    } csr_state_t;

endpackage

// File: rtl/lcdc_reg_store.sv
module lcdc_reg_store
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output csr_state_t        state_o
);

    csr_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.en_chg = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_W'(OFS_CTRL): begin
                    st_d.plm       = wdata[PLM_LSB +: 2];
                    st_d.tft       = wdata[TFT_BIT];
                    st_d.irq_mask  = wdata[MASK_LSB +: NUM_MASKED];
                    st_d.mono      = wdata[MONO_BIT];
                    st_d.ctrl_keep = wdata & CTRL_KEEP_MASK;
                    st_d.enable    = wdata[EN_BIT];
                    st_d.en_chg    = wdata[EN_BIT] ^ st_q.enable;
                end
                ADDR_W'(OFS_GEOM_X): begin
                    st_d.width = {1'b0, wdata[GEOM_W-1:0]} + (GEOM_W+1)'(1);
                    st_d.timf0 = wdata[DATA_W-1:GEOM_W];
                end
                ADDR_W'(OFS_GEOM_Y): begin
                    st_d.height = {1'b0, wdata[GEOM_W-1:0]} + (GEOM_W+1)'(1);
                    st_d.timf1  = wdata[DATA_W-1:GEOM_W];
                end
                ADDR_W'(OFS_TIMRAW): begin
                    st_d.timraw = wdata;
                end
                ADDR_W'(OFS_SUBP): begin
                    st_d.subpanel = wdata & SUBP_KEEP_MASK;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/lcdc_rd_mux.sv
module lcdc_rd_mux
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  enable,
    input  logic [1:0]            plm,
    input  logic                  tft,
    input  logic                  mono,
    input  logic [NUM_MASKED-1:0] irq_mask,
    input  logic [DATA_W-1:0]     ctrl_keep,
    input  logic [GEOM_W-1:0]     width_lo,
    input  logic [TIMF_W-1:0]     timf0,
    input  logic [GEOM_W-1:0]     height_lo,
    input  logic [TIMF_W-1:0]     timf1,
    input  logic [DATA_W-1:0]     timraw,
    input  logic [DATA_W-1:0]     subpanel,
    input  logic                  frame_done,
    input  logic                  palette_done,
    input  logic                  sync_err,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] stat_word;
    logic [GEOM_W-1:0] width_m1;
    logic [GEOM_W-1:0] height_m1;

    always_comb begin
        ctrl_word = ctrl_keep | CTRL_RD_ONES
                  | (DATA_W'(tft)      << TFT_DUP_BIT)
                  | (DATA_W'(plm)      << PLM_LSB)
                  | (DATA_W'(tft)      << TFT_BIT)
                  | (DATA_W'(irq_mask) << MASK_LSB)
                  | (DATA_W'(mono)     << MONO_BIT)
                  | (DATA_W'(enable)   << EN_BIT);

        stat_word = (DATA_W'(palette_done) << ST_PAL_BIT)
                  | (DATA_W'(sync_err)     << ST_SYNC_BIT)
                  | (DATA_W'(frame_done)   << ST_FRAME_BIT);

        width_m1  = width_lo  - GEOM_W'(1);
        height_m1 = height_lo - GEOM_W'(1);

        case (addr)
            ADDR_W'(OFS_CTRL):   rdata = ctrl_word;
            ADDR_W'(OFS_GEOM_X): rdata = {timf0, width_m1} | GEOMX_RD_ONES;
            ADDR_W'(OFS_GEOM_Y): rdata = {timf1, height_m1};
            ADDR_W'(OFS_TIMRAW): rdata = timraw | TIMRAW_RD_ONES;
            ADDR_W'(OFS_STAT):   rdata = stat_word;
            ADDR_W'(OFS_SUBP):   rdata = subpanel;
            default:             rdata = '0;
        endcase
    end

endmodule

// File: rtl/lcdc_irq_comb.sv
module lcdc_irq_comb
    import lcdc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_MASKED-1:0] mask,
    input  logic [NUM_MASKED-1:0] masked_src,
    input  logic                  unmasked_src,
    output logic                  irq_o
);

    logic [NUM_MASKED-1:0] gated;
    logic                  irq_d, irq_q;

    for (genvar gi = 0; gi < NUM_MASKED; gi++) begin : g_gate
        assign gated[gi] = masked_src[gi] & mask[gi];
    end

    always_comb begin
        irq_d = (|gated) | unmasked_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/lcdc_csr.sv
module lcdc_csr
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              frame_done_i,
    input  logic              palette_done_i,
    input  logic              sync_err_i,
    output logic              irq_o,
    output logic              enable_o,
    output logic              enable_chg_o,
    output logic [1:0]        plm_o,
    output logic              tft_o,
    output logic              mono_o,
    output logic [10:0]       width_o,
    output logic [10:0]       height_o,
    output logic [31:0]       subpanel_o
);

    csr_state_t            st;
    logic [NUM_MASKED-1:0] irq_mask_w;

    lcdc_reg_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .state_o (st)
    );

    assign irq_mask_w = st.irq_mask;

    lcdc_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
        .addr         (addr),
        .enable       (st.enable),
        .plm          (st.plm),
        .tft          (st.tft),
        .mono         (st.mono),
        .irq_mask     (st.irq_mask),
        .ctrl_keep    (st.ctrl_keep),
        .width_lo     (st.width[GEOM_W-1:0]),
        .timf0        (st.timf0),
        .height_lo    (st.height[GEOM_W-1:0]),
        .timf1        (st.timf1),
        .timraw       (st.timraw),
        .subpanel     (st.subpanel),
        .frame_done   (frame_done_i),
        .palette_done (palette_done_i),
        .sync_err     (sync_err_i),
        .rdata        (rdata)
    );

    lcdc_irq_comb u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask         (irq_mask_w),
        .masked_src   ({palette_done_i, frame_done_i}),
        .unmasked_src (sync_err_i),
        .irq_o        (irq_o)
    );

    assign enable_o     = st.enable;
    assign enable_chg_o = st.en_chg;
    assign plm_o        = st.plm;
    assign tft_o        = st.tft;
    assign mono_o       = st.mono;
    assign width_o      = st.width;
    assign height_o     = st.height;
    assign subpanel_o   = st.subpanel;

endmodule

// File: rtl/lcdc_csr_chk.sv
module lcdc_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [7:0]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        frame_done_i,
    input logic        palette_done_i,
    input logic        sync_err_i,
    input logic [1:0]  irq_mask_w,
    input logic        irq_o,
    input logic        enable_o,
    input logic        enable_chg_o,
    input logic [10:0] width_o,
    input logic [10:0] height_o,
    input logic [31:0] subpanel_o
);

    logic armed;
    logic unmapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign unmapped = !(addr inside {8'h00, 8'h04, 8'h08, 8'h0c, 8'h10, 8'h14});

    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> irq_o == (($past(frame_done_i) & $past(irq_mask_w[0]))
                          | ($past(palette_done_i) & $past(irq_mask_w[1]))
                          | $past(sync_err_i)));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        enable_chg_o |=> !enable_chg_o);

    assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && enable_chg_o) |-> enable_o != $past(enable_o));

    assert_width_plus1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h04) |=> width_o == ({1'b0, $past(wdata[9:0])} + 11'd1));

    assert_status_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h10) |=> ($stable(width_o) && $stable(height_o)
                                      && $stable(subpanel_o) && $stable(enable_o)));

    assert_subpanel_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h14) |=> subpanel_o == ($past(wdata) & 32'ha1ff_ffff));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> rdata == 32'h0);

endmodule

bind lcdc_csr lcdc_csr_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .rdata          (rdata),
    .frame_done_i   (frame_done_i),
    .palette_done_i (palette_done_i),
    .sync_err_i     (sync_err_i),
    .irq_mask_w     (irq_mask_w),
    .irq_o          (irq_o),
    .enable_o       (enable_o),
    .enable_chg_o   (enable_chg_o),
    .width_o        (width_o),
    .height_o       (height_o),
    .subpanel_o     (subpanel_o)
);

// File: tb/tb_lcdc_csr.sv
`timescale 1ns/1ps
module tb_lcdc_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        fd = 1'b0, pd = 1'b0, se = 1'b0;
    logic        irq_o, enable_o, enable_chg_o, tft_o, mono_o;
    logic [1:0]  plm_o;
    logic [10:0] width_o, height_o;
    logic [31:0] subpanel_o;

    always #2 clk = ~clk;

    lcdc_csr dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .frame_done_i(fd), .palette_done_i(pd), .sync_err_i(se),
        .irq_o(irq_o), .enable_o(enable_o), .enable_chg_o(enable_chg_o),
        .plm_o(plm_o), .tft_o(tft_o), .mono_o(mono_o), .width_o(width_o),
        .height_o(height_o), .subpanel_o(subpanel_o)
    );

    typedef enum int {K_RD, K_IRQ, K_EN, K_CHG, K_W, K_H, K_SUB, K_PLM, K_TFT, K_MONO} kind_t;
    typedef struct {
        kind_t       kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;

    function automatic logic [31:0] observe(kind_t k);
        case (k)
            K_RD:    return rdata;
            K_IRQ:   return 32'(irq_o);
            K_EN:    return 32'(enable_o);
            K_CHG:   return 32'(enable_chg_o);
            K_W:     return 32'(width_o);
            K_H:     return 32'(height_o);
            K_SUB:   return subpanel_o;
            K_PLM:   return 32'(plm_o);
            K_TFT:   return 32'(tft_o);
            default: return 32'(mono_o);
        endcase
    endfunction

    // Monitor: pops every pending expectation at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = observe(it.kind);
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(kind_t k, logic [31:0] e, string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] e, string r);
        addr = a;
        push(K_RD, e, r);
        settle();
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] exp_ctrl(logic [31:0] w);
        logic [31:0] v;
        v = (w & 32'h01cf_f300) | 32'hfe00_0c34;
        v = v | (32'(w[7]) << 23) | (32'(w[21:20]) << 20) | (32'(w[7]) << 7);
        v = v | (32'(w[4:3]) << 3) | (32'(w[1]) << 1) | 32'(w[0]);
        return v;
    endfunction

    function automatic logic [31:0] exp_geom(logic [31:0] w, logic [31:0] ones);
        return ({w[31:10], w[9:0]}) | ones;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R1: reset state
        rd_chk(8'h00, 32'hfe00_0c34, "R1 ctrl");
        rd_chk(8'h04, 32'h0000_03ff, "R1 geom x");
        rd_chk(8'h08, 32'h0000_03ff, "R1 geom y");
        rd_chk(8'h0c, 32'hfc00_0000, "R1 timraw");
        rd_chk(8'h10, 32'h0,         "R1 status");
        rd_chk(8'h14, 32'h0,         "R1 subpanel");
        push(K_EN, 0, "R1 enable"); push(K_W, 0, "R1 width");
        push(K_H, 0, "R1 height"); push(K_IRQ, 0, "R1 irq");
        push(K_CHG, 0, "R1 pulse"); push(K_SUB, 0, "R1 sub");
        settle();

        // R2 R10: enable rising via control write
        wr(8'h00, 32'h0030_0099);
        push(K_EN, 1, "R2 enable"); push(K_PLM, 3, "R2 plm");
        push(K_TFT, 1, "R2 tft"); push(K_MONO, 0, "R2 mono");
        push(K_CHG, 1, "R10 pulse on rise");
        rd_chk(8'h00, exp_ctrl(32'h0030_0099), "R3 ctrl read a");
        tick();
        push(K_CHG, 0, "R10 pulse one cycle"); settle();
        // same enable value: no pulse
        wr(8'h00, 32'h0010_0003);
        push(K_CHG, 0, "R10 no pulse same enable"); push(K_MONO, 1, "R2 mono");
        push(K_PLM, 1, "R2 plm b");
        rd_chk(8'h00, exp_ctrl(32'h0010_0003), "R3 ctrl read b");
        wr(8'h00, 32'hffff_fffe);
        push(K_CHG, 1, "R10 pulse on fall"); push(K_EN, 0, "R2 enable fall");
        rd_chk(8'h00, exp_ctrl(32'hffff_fffe), "R3 ctrl read c");

        // R4 R5: geometry
        wr(8'h04, 32'habcd_e123);
        push(K_W, 32'h124, "R4 width");
        rd_chk(8'h04, exp_geom(32'habcd_e123, 32'hf), "R4 read");
        wr(8'h04, 32'h0000_03ff);
        push(K_W, 32'h400, "R4 width max");
        rd_chk(8'h04, 32'h0000_03ff, "R4 read max");
        wr(8'h08, 32'h1234_5400);
        push(K_H, 32'h1, "R5 height min");
        rd_chk(8'h08, 32'h1234_5400, "R5 read min");
        wr(8'h08, 32'h8000_0050);
        push(K_H, 32'h51, "R5 height");
        rd_chk(8'h08, 32'h8000_0050, "R5 read");

        // R6: raw timing
        wr(8'h0c, 32'h1234_5678);
        rd_chk(8'h0c, 32'hfe34_5678, "R6 read");

        // R8: subpanel mask
        wr(8'h14, 32'hffff_ffff);
        push(K_SUB, 32'ha1ff_ffff, "R8 out");
        rd_chk(8'h14, 32'ha1ff_ffff, "R8 read");

        // R7: status mirror and write ignored
        fd = 1'b1; pd = 1'b0; se = 1'b1;
        rd_chk(8'h10, 32'h0000_0005, "R7 status a");
        fd = 1'b0; pd = 1'b1; se = 1'b0;
        rd_chk(8'h10, 32'h0000_0040, "R7 status b");
        pd = 1'b0;
        wr(8'h10, 32'hffff_ffff);
        rd_chk(8'h10, 32'h0, "R7 status after write");
        rd_chk(8'h0c, 32'hfe34_5678, "R7 timraw untouched");
        rd_chk(8'h04, 32'h0000_03ff, "R7 geom untouched");
        push(K_SUB, 32'ha1ff_ffff, "R7 sub untouched"); settle();

        // R9: interrupt combine, mask off
        wr(8'h00, 32'h0);
        fd = 1'b1; pd = 1'b1; tick();
        push(K_IRQ, 0, "R9 masked off"); settle();
        se = 1'b1; tick();
        push(K_IRQ, 1, "R9 sync unmasked"); settle();
        se = 1'b0; pd = 1'b0;
        wr(8'h00, 32'h0000_0008);
        tick();
        push(K_IRQ, 1, "R9 frame with mask0"); settle();
        fd = 1'b0; pd = 1'b1; tick();
        push(K_IRQ, 0, "R9 palette without mask1"); settle();
        wr(8'h00, 32'h0000_0010);
        tick();
        push(K_IRQ, 1, "R9 palette with mask1"); settle();
        pd = 1'b0; tick();
        push(K_IRQ, 0, "R9 all clear"); settle();

        // R11: unmapped and misaligned
        rd_chk(8'h18, 32'h0, "R11 read 0x18");
        rd_chk(8'h02, 32'h0, "R11 read 0x02");
        rd_chk(8'hfc, 32'h0, "R11 read 0xfc");
        wr(8'h18, 32'hffff_ffff);
        wr(8'h06, 32'h0000_0001);
        wr(8'h0e, 32'h0000_0000);
        rd_chk(8'h04, 32'h0000_03ff, "R11 geom x kept");
        rd_chk(8'h0c, 32'hfe34_5678, "R11 timraw kept");
        rd_chk(8'h00, exp_ctrl(32'h0000_0010), "R11 ctrl kept");
        push(K_W, 32'h400, "R11 width kept"); settle();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule